// File: doc/BRIEF.md
# Interrupt translator control register block

This block is the memory-mapped control face of an interrupt translation unit. Software reaches it over a simple register bus with 64-bit data, where 32-bit registers use the low half. Through it, software turns the unit on and off and reads a fixed identification word. It also programs the device table layout and base address, and asks for cache invalidation of a single event or of a whole device. A per-device synchronisation request is also available.

Every operation that changes state runs an idle/busy handshake. Software starts the operation with a trigger write. The matching idle bit then reads 0 for a fixed number of cycles, set by the `LAT` parameter, and returns to 1 when the modelled work is done. Invalidation is addressed in stages. Software first writes a device ID register and, for event invalidation, an event ID register. The trigger write then fires a one-cycle command pulse at the block's outputs, carrying the staged IDs.

The device table configuration is locked while the unit is enabled or while an enable transition is in progress. A trigger that arrives while its operation is still busy is dropped. Both of these faults set a sticky error bit.

Top module: `xlat_ctrl`

Register offsets (bytes): 0x00 control, 0x08 identification, 0x10 table config, 0x18 table base, 0x20 staged device ID, 0x28 staged event ID, 0x30 event-invalidate trigger, 0x38 device-invalidate trigger, 0x40 invalidate status, 0x48 sync trigger, 0x50 sync status, 0x58 error. Reads have one cycle of latency.

## Requirements
- R1: After reset the control register reads 2 (enable bit 0 = 0, idle bit 1 = 1). The invalidate status and sync status registers read 1 (idle, bit 0). The error register and the table config read 0, and `unit_en` is 0.
- R2: A write to control starts an enable transition. Control bit 1 reads 0 for exactly `LAT` cycles after the write. `unit_en` takes the written bit 0 in the cycle in which idle returns to 1.
- R3: A write of bit 0 = 1 to the event-invalidate trigger while invalidation is idle has three effects in the cycle after the write. `inv_fire` pulses for one cycle, `inv_by_dev` reads 0, and `inv_dev_id` and `inv_evt_id` show the staged device and event IDs. The invalidate status bit 0 then reads 0 for exactly `LAT` cycles.
- R4: A write to the device-invalidate trigger with bit 0 = 1 (I) fires `inv_fire` with `inv_by_dev` = 1 and the staged device ID. The same write carries an event-ID width in bits 5:1 and an L1 flag in bit 6. Both fields read back at that offset, with bit 0 reading 0.
- R5: A sync trigger write with bit 0 = 1 and the device ID in bits 32 and up has two effects. It pulses `sync_fire` with that ID on `sync_dev_id`, and sync status reads 0 for `LAT` cycles. Sync is independent of invalidation.
- R6: A trigger write with bit 0 = 0 does nothing: no pulse, status stays idle, and the error bit stays 0.
- R7: A trigger written while its operation is busy is ignored and the error register bit 0 becomes 1. Writing 1 to error bit 0 clears it.
- R8: While the unit is disabled and idle, the table config reads back write bits [0] (two-level), [2:1] (level-2 size code) and [8:4] (device-ID bits), with other bits 0. The table base reads back bits 63:12, with the low 12 bits 0. While `unit_en` = 1 or an enable transition is busy, writes to both registers are ignored and set the error bit.
- R9: Reads of an unmapped offset return 0, and writes to one change no register.
- R10: The identification register reads `DEVID_W` in bits 7:0, `EVTID_W` in bits 15:8, and 1 in bit 16 (two-level support).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, one cycle after the strobe |
| bus_rvalid | output | 1 | Read data valid |
| unit_en | output | 1 | Effective enable state |
| inv_fire | output | 1 | One-cycle invalidation command pulse |
| inv_by_dev | output | 1 | Command is a device-wide invalidation |
| inv_dev_id | output | DEVID_W | Device ID of the command |
| inv_evt_id | output | EVTID_W | Event ID of the command (0 for device-wide) |
| sync_fire | output | 1 | One-cycle sync command pulse |
| sync_dev_id | output | DEVID_W | Device ID of the sync command |

## Verification
The embedded assertions check five properties on every cycle:
- each command pulse coincides with a busy timer;
- two pulses never come back to back;
- a busy period lasts exactly `LAT` cycles and then returns to idle;
- `unit_en` moves only at the end of a transition;
- locked table registers hold, and a trigger during busy sets the error bit.

Only the bench scenarios show the register-level results: the readback masks, the staged IDs reaching the outputs, that rejected or unmapped writes leave the rest untouched, and that software polling sees exactly `LAT` busy reads.

// File: rtl/xlat_ctrl_pkg.sv
package xlat_ctrl_pkg;

  localparam logic [7:0] OFS_CTRL     = 8'h00;
  localparam logic [7:0] OFS_IDENT    = 8'h08;
  localparam logic [7:0] OFS_DTCFG    = 8'h10;
  localparam logic [7:0] OFS_DTBASE   = 8'h18;
  localparam logic [7:0] OFS_DEVID    = 8'h20;
  localparam logic [7:0] OFS_EVTID    = 8'h28;
  localparam logic [7:0] OFS_INVEVT   = 8'h30;
  localparam logic [7:0] OFS_INVDEV   = 8'h38;
  localparam logic [7:0] OFS_INVSTAT  = 8'h40;
  localparam logic [7:0] OFS_SYNC     = 8'h48;
  localparam logic [7:0] OFS_SYNCSTAT = 8'h50;
  localparam logic [7:0] OFS_ERR      = 8'h58;

  localparam int NUM_TMR  = 3;
  localparam int TMR_CTRL = 0;
  localparam int TMR_INV  = 1;
  localparam int TMR_SYNC = 2;

  localparam int BASE_ALIGN = 12;

  typedef struct packed {
    logic [4:0] id_bits;
    logic       rsv;
    logic [1:0] l2sz;
    logic       two_level;
  } dtcfg_t;

  function automatic dtcfg_t unpack_dtcfg(logic [8:0] w);
    dtcfg_t c;
    c     = w;
    c.rsv = 1'b0;
    return c;
  endfunction

  function automatic logic [63:0] pack_dtcfg(dtcfg_t c);
    return {55'b0, c};
  endfunction

  function automatic logic [63:0] align_base(logic [63:0] w);
    return {w[63:BASE_ALIGN], {BASE_ALIGN{1'b0}}};
  endfunction

  function automatic logic [63:0] ident_word(int dev_w, int evt_w);
    return {47'b0, 1'b1, 8'(evt_w), 8'(dev_w)};
  endfunction

endpackage

// File: rtl/xlat_busy_timer.sv
module xlat_busy_timer #(
  parameter int LAT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(LAT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (start && cnt == '0) cnt <= CW'(LAT);
    else if (cnt != '0)        cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
  assign done = (cnt == CW'(1));

  // checker: length of each busy window
  logic [CW:0] run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run <= '0;
    else if (busy) run <= run + 1'b1;
    else           run <= '0;
  end

  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_busy_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run < (CW+1)'(LAT)));

  p_busy_exact_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(run) == (CW+1)'(LAT - 1)));

endmodule

// File: rtl/xlat_dt_regs.sv
module xlat_dt_regs
  import xlat_ctrl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lock,
  input  logic        wr_cfg,
  input  logic        wr_base,
  input  logic [8:0]  cfg_w,
  input  logic [63:0] base_w,
  output dtcfg_t      cfg,
  output logic [63:0] base,
  output logic        reject
);

  assign reject = lock && (wr_cfg || wr_base);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg  <= '0;
      base <= '0;
    end else if (!lock) begin
      if (wr_cfg)  cfg  <= unpack_dtcfg(cfg_w);
      if (wr_base) base <= align_base(base_w);
    end
  end

  p_cfg_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> ($stable(cfg) && $stable(base)));

endmodule

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DEVID_W = 16,
  parameter int EVTID_W = 12,
  parameter int LAT     = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [63:0]        bus_wdata,
  output logic [63:0]        bus_rdata,
  output logic               bus_rvalid,
  output logic               unit_en,
  output logic               inv_fire,
  output logic               inv_by_dev,
  output logic [DEVID_W-1:0] inv_dev_id,
  output logic [EVTID_W-1:0] inv_evt_id,
  output logic               sync_fire,
  output logic [DEVID_W-1:0] sync_dev_id
);

  function automatic logic at(logic [ADDR_W-1:0] a, logic [7:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  // write decode
  logic w_ctrl, w_dtcfg, w_dtbase, w_devid, w_evtid;
  logic w_invevt, w_invdev, w_sync, w_err;
  assign w_ctrl   = bus_wr && at(bus_addr, OFS_CTRL);
  assign w_dtcfg  = bus_wr && at(bus_addr, OFS_DTCFG);
  assign w_dtbase = bus_wr && at(bus_addr, OFS_DTBASE);
  assign w_devid  = bus_wr && at(bus_addr, OFS_DEVID);
  assign w_evtid  = bus_wr && at(bus_addr, OFS_EVTID);
  assign w_invevt = bus_wr && at(bus_addr, OFS_INVEVT);
  assign w_invdev = bus_wr && at(bus_addr, OFS_INVDEV);
  assign w_sync   = bus_wr && at(bus_addr, OFS_SYNC);
  assign w_err    = bus_wr && at(bus_addr, OFS_ERR);

  // busy timers
  logic [NUM_TMR-1:0] t_start, t_busy, t_done;
  for (genvar gi = 0; gi < NUM_TMR; gi++) begin : g_tmr
    xlat_busy_timer #(.LAT(LAT)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .start (t_start[gi]),
      .busy  (t_busy[gi]),
      .done  (t_done[gi])
    );
  end

  // trigger acceptance
  logic ctrl_req, inv_req, sync_req;
  logic ctrl_go, inv_go, sync_go, trig_rej;
  assign ctrl_req = w_ctrl;
  assign inv_req  = (w_invevt || w_invdev) && bus_wdata[0];
  assign sync_req = w_sync && bus_wdata[0];
  assign ctrl_go  = ctrl_req && !t_busy[TMR_CTRL];
  assign inv_go   = inv_req  && !t_busy[TMR_INV];
  assign sync_go  = sync_req && !t_busy[TMR_SYNC];
  assign trig_rej = (ctrl_req && t_busy[TMR_CTRL]) ||
                    (inv_req  && t_busy[TMR_INV])  ||
                    (sync_req && t_busy[TMR_SYNC]);

  always_comb begin
    t_start           = '0;
    t_start[TMR_CTRL] = ctrl_go;
    t_start[TMR_INV]  = inv_go;
    t_start[TMR_SYNC] = sync_go;
  end

  // device table registers
  dtcfg_t      dt_cfg;
  logic [63:0] dt_base;
  logic        dt_lock, dt_rej;
  assign dt_lock = unit_en || t_busy[TMR_CTRL];

  xlat_dt_regs u_dt (
    .clk     (clk),
    .rst_n   (rst_n),
    .lock    (dt_lock),
    .wr_cfg  (w_dtcfg),
    .wr_base (w_dtbase),
    .cfg_w   (bus_wdata[8:0]),
    .base_w  (bus_wdata),
    .cfg     (dt_cfg),
    .base    (dt_base),
    .reject  (dt_rej)
  );

  // state
  logic               en_pend, err;
  logic [DEVID_W-1:0] dev_stage;
  logic [EVTID_W-1:0] evt_stage;
  logic [4:0]         invdev_evbits;
  logic               invdev_l1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_pend       <= 1'b0;
      unit_en       <= 1'b0;
      err           <= 1'b0;
      dev_stage     <= '0;
      evt_stage     <= '0;
      invdev_evbits <= '0;
      invdev_l1     <= 1'b0;
      inv_fire      <= 1'b0;
      inv_by_dev    <= 1'b0;
      inv_dev_id    <= '0;
      inv_evt_id    <= '0;
      sync_fire     <= 1'b0;
      sync_dev_id   <= '0;
    end else begin
      if (ctrl_go)          en_pend   <= bus_wdata[0];
      if (t_done[TMR_CTRL]) unit_en   <= en_pend;
      if (w_devid)          dev_stage <= bus_wdata[DEVID_W-1:0];
      if (w_evtid)          evt_stage <= bus_wdata[EVTID_W-1:0];

      inv_fire <= inv_go;
      if (inv_go) begin
        inv_by_dev <= w_invdev;
        inv_dev_id <= dev_stage;
        inv_evt_id <= w_invdev ? '0 : evt_stage;
        if (w_invdev) begin
          invdev_evbits <= bus_wdata[5:1];
          invdev_l1     <= bus_wdata[6];
        end
      end

      sync_fire <= sync_go;
      if (sync_go) sync_dev_id <= bus_wdata[32 +: DEVID_W];

      if (trig_rej || dt_rej)       err <= 1'b1;
      else if (w_err && bus_wdata[0]) err <= 1'b0;
    end
  end

  // read path
  logic [63:0] rd_word;
  always_comb begin
    rd_word = '0;
    if      (at(bus_addr, OFS_CTRL))     rd_word = {62'b0, !t_busy[TMR_CTRL], en_pend};
    else if (at(bus_addr, OFS_IDENT))    rd_word = ident_word(DEVID_W, EVTID_W);
    else if (at(bus_addr, OFS_DTCFG))    rd_word = pack_dtcfg(dt_cfg);
    else if (at(bus_addr, OFS_DTBASE))   rd_word = dt_base;
    else if (at(bus_addr, OFS_DEVID))    rd_word = 64'(dev_stage);
    else if (at(bus_addr, OFS_EVTID))    rd_word = 64'(evt_stage);
    else if (at(bus_addr, OFS_INVDEV))   rd_word = {57'b0, invdev_l1, invdev_evbits, 1'b0};
    else if (at(bus_addr, OFS_INVSTAT))  rd_word = {63'b0, !t_busy[TMR_INV]};
    else if (at(bus_addr, OFS_SYNCSTAT)) rd_word = {63'b0, !t_busy[TMR_SYNC]};
    else if (at(bus_addr, OFS_ERR))      rd_word = {63'b0, err};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_word;
    end
  end

  p_fire_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    inv_fire |-> t_busy[TMR_INV]);

  p_sync_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sync_fire |-> t_busy[TMR_SYNC]);

  p_no_back2back_r7: assert property (@(posedge clk) disable iff (!rst_n)
    inv_fire |=> !inv_fire);

  p_reject_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_req && t_busy[TMR_INV]) |=> err);

  p_en_moves_at_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(unit_en) |-> $past(t_busy[TMR_CTRL]));

  p_inv_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    t_done[TMR_INV] |=> !t_busy[TMR_INV]);

  p_sync_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    t_done[TMR_SYNC] |=> !t_busy[TMR_SYNC]);

endmodule

// File: tb/xlat_ctrl_test.sv
module xlat_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 8;
  localparam int DEVID_W = 16;
  localparam int EVTID_W = 12;

  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_addr = 0;
  logic [63:0] bus_wdata = 0, bus_rdata;
  logic bus_rvalid, unit_en, inv_fire, inv_by_dev, sync_fire;
  logic [DEVID_W-1:0] inv_dev_id, sync_dev_id;
  logic [EVTID_W-1:0] inv_evt_id;

  int checks = 0, errors = 0;
  bit done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlat_ctrl #(.ADDR_W(8), .DEVID_W(DEVID_W), .EVTID_W(EVTID_W), .LAT(LAT)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .unit_en(unit_en), .inv_fire(inv_fire),
    .inv_by_dev(inv_by_dev), .inv_dev_id(inv_dev_id), .inv_evt_id(inv_evt_id),
    .sync_fire(sync_fire), .sync_dev_id(sync_dev_id));

  function automatic logic [63:0] exp_cfg(logic [63:0] w);
    return w & 64'h1F7;
  endfunction
  function automatic logic [63:0] exp_base(logic [63:0] w);
    return w & ~64'hFFF;
  endfunction
  function automatic logic [63:0] exp_ident();
    return (64'd1 << 16) | (64'(EVTID_W) << 8) | 64'(DEVID_W);
  endfunction

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bwrite(logic [7:0] a, logic [63:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic bread(logic [7:0] a, output logic [63:0] d);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    @(posedge clk); #1;
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic count_busy(logic [7:0] a, int bitpos, output int n);
    logic [63:0] d;
    n = 0;
    for (int k = 0; k < 60; k++) begin
      bread(a, d);
      if (d[bitpos]) break;
      n++;
    end
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [63:0] d, w;
    int n;
    int unsigned seed;
    logic [15:0] dv;
    logic [11:0] ev;
    seed = 32'h5eed;
    void'($urandom(seed));

    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    bread(8'h00, d); check("R1 ctrl", d, 64'd2);
    bread(8'h40, d); check("R1 invstat", d, 64'd1);
    bread(8'h50, d); check("R1 syncstat", d, 64'd1);
    bread(8'h58, d); check("R1 err", d, 64'd0);
    bread(8'h10, d); check("R1 dtcfg", d, 64'd0);
    check("R1 unit_en", 64'(unit_en), 64'd0);

    // R10 identification
    bread(8'h08, d); check("R10 ident", d, exp_ident());

    // R9 unmapped
    bread(8'h60, d); check("R9 read 0x60", d, 64'd0);
    bread(8'h04, d); check("R9 read 0x04", d, 64'd0);
    bwrite(8'h60, '1);
    bwrite(8'h14, '1);
    bread(8'h58, d); check("R9 err untouched", d, 64'd0);
    bread(8'h00, d); check("R9 ctrl untouched", d, 64'd2);
    bread(8'h10, d); check("R9 dtcfg untouched", d, 64'd0);

    // R8 config while disabled, random
    for (int i = 0; i < 6; i++) begin
      w = {$urandom(), $urandom()};
      bwrite(8'h10, w);
      bread(8'h10, d); check("R8 dtcfg readback", d, exp_cfg(w));
      w = {$urandom(), $urandom()};
      bwrite(8'h18, w);
      bread(8'h18, d); check("R8 dtbase readback", d, exp_base(w));
    end

    // R6 trigger bits clear
    bwrite(8'h30, 64'hFFFF_FFFF_FFFF_FFFE);
    check("R6 no inv_fire", 64'(inv_fire), 64'd0);
    bread(8'h40, d); check("R6 invstat idle", d, 64'd1);
    bwrite(8'h48, 64'h0000_1234_0000_0000);
    check("R6 no sync_fire", 64'(sync_fire), 64'd0);
    bread(8'h50, d); check("R6 syncstat idle", d, 64'd1);
    bread(8'h58, d); check("R6 err", d, 64'd0);

    // R3 random event invalidations
    for (int i = 0; i < 8; i++) begin
      dv = 16'($urandom());
      ev = 12'($urandom());
      bwrite(8'h20, 64'(dv));
      bwrite(8'h28, 64'(ev));
      bwrite(8'h30, 64'd1);
      check("R3 inv_fire", 64'(inv_fire), 64'd1);
      check("R3 by_dev", 64'(inv_by_dev), 64'd0);
      check("R3 dev id", 64'(inv_dev_id), 64'(dv));
      check("R3 evt id", 64'(inv_evt_id), 64'(ev));
      count_busy(8'h40, 0, n);
      check("R3 busy length", 64'(n), 64'(LAT));
      check("R3 pulse ended", 64'(inv_fire), 64'd0);
    end

    // R4 device invalidation
    bwrite(8'h20, 64'h0000_0000_0000_ABCD);
    bwrite(8'h38, (64'd1 << 6) | (64'd13 << 1) | 64'd1);
    check("R4 inv_fire", 64'(inv_fire), 64'd1);
    check("R4 by_dev", 64'(inv_by_dev), 64'd1);
    check("R4 dev id", 64'(inv_dev_id), 64'hABCD);
    count_busy(8'h40, 0, n);
    check("R4 busy length", 64'(n), 64'(LAT));
    bread(8'h38, d); check("R4 fields readback", d, 64'h5A);

    // R5 sync alone, then sync overlapping an invalidation
    bwrite(8'h48, (64'h0000_0000_0000_4321 << 32) | 64'd1);
    check("R5 sync_fire", 64'(sync_fire), 64'd1);
    check("R5 sync dev", 64'(sync_dev_id), 64'h4321);
    count_busy(8'h50, 0, n);
    check("R5 sync busy length", 64'(n), 64'(LAT));
    bwrite(8'h48, (64'h0000_0000_0000_0777 << 32) | 64'd1);
    bwrite(8'h30, 64'd1);
    check("R5 inv accepted during sync", 64'(inv_fire), 64'd1);
    bread(8'h50, d); check("R5 sync busy", d, 64'd0);
    count_busy(8'h40, 0, n);
    count_busy(8'h50, 0, n);
    bread(8'h58, d); check("R5 no err", d, 64'd0);

    // R7 trigger while busy
    bwrite(8'h20, 64'h0000_0000_0000_1111);
    bwrite(8'h30, 64'd1);
    bwrite(8'h20, 64'h0000_0000_0000_2222);
    bwrite(8'h30, 64'd1);
    check("R7 no second fire", 64'(inv_fire), 64'd0);
    check("R7 dev id kept", 64'(inv_dev_id), 64'h1111);
    bread(8'h58, d); check("R7 err set", d, 64'd1);
    bwrite(8'h58, 64'd1);
    bread(8'h58, d); check("R7 err cleared", d, 64'd0);
    count_busy(8'h40, 0, n);

    // R2 enable transition
    w = 64'h0000_0000_0000_0025;
    bwrite(8'h10, w);
    bwrite(8'h00, 64'd1);
    check("R2 unit_en not yet", 64'(unit_en), 64'd0);
    count_busy(8'h00, 1, n);
    check("R2 busy length", 64'(n), 64'(LAT));
    check("R2 unit_en on", 64'(unit_en), 64'd1);
    bread(8'h00, d); check("R2 ctrl readback", d, 64'd3);

    // R8 locked while enabled
    bwrite(8'h10, 64'h1F0);
    bread(8'h10, d); check("R8 dtcfg locked", d, exp_cfg(w));
    bread(8'h58, d); check("R8 err set", d, 64'd1);
    bwrite(8'h58, 64'd1);
    bwrite(8'h00, 64'd0);
    count_busy(8'h00, 1, n);
    check("R2 disable length", 64'(n), 64'(LAT));
    check("R2 unit_en off", 64'(unit_en), 64'd0);

    summary();
  end
endmodule